// File: doc/BRIEF.md
# Multiplexed Memory Bus Sequencer

This block sits between a processor core and a memory bus that carries both address and data on one set of wires. On the core side it takes read requests and write requests. A read request is an instruction-cache refill, a data-cache refill or an uncached load. A write request is a store drained from a write queue. For each transaction it puts the address on the shared lines and pulses the latch strobe. If configured, it keeps the address on the lines for one extra cycle. It then opens the data phase with a read or write strobe and, on a read, counts returned words until the refill is complete.

Two sources set the timing and signalling options. A data-refill size and the initial byte order are captured from mode pins, and only while reset is high. A software-writable control register selects extended address hold, bus turnaround insertion, byte order, and the read/write qualification of two general-purpose memory strobes. The block copies the register into the transaction when it accepts that transaction, so a write to the register takes effect only from the next transaction.

Top module: `mbus_ctrl`

## Requirements
- R1: An instruction refill (kind 0) always returns 4 words. An uncached read (kind 2, also kind 3) and every write always transfer exactly 1 word.
- R2: A data refill (kind 1) transfers 4 words when `mode_dref4` was 1 during reset, and 1 word when it was 0.
- R3: The read data phase delivers one word on each cycle with `bus_ack` high. The word index `rdata_idx` starts at request address bits [3:2] and wraps modulo 4. A cycle without `bus_ack` delivers nothing and keeps `bus_rd` high.
- R4: Every transaction begins with exactly one cycle of `bus_ale` high, with the request address driven and `bus_ad_oe` high. With hold extension (register bit 1) set, one further cycle keeps the address driven with `bus_ale` low before the data strobe. Out of reset the bus is idle.
- R5: With turnaround (register bit 0) set, the first transaction whose direction differs from the previous one gets one idle cycle, with nothing driven, before its latch cycle. Otherwise there is no gap. Direction after reset counts as read.
- R6: Strobe A uses register bits [4:3] and strobe B uses bits [6:5]. The encoding is 0 never, 1 reads only, 2 writes only, 3 both. A strobe is active only during the data phase.
- R7: Byte enables for size 0 (byte), 1 (half) and 2 (word) come from the low address bits. In little-endian order (register bit 2 = 0) the byte at offset k uses lane k. In big-endian order it uses lane 3-k. Refill reads always enable all lanes.
- R8: A register write during a transaction does not change that transaction. It applies from the next accepted request.
- R9: A read and a write offered together: the read is accepted. A write is accepted only when the block is idle and no read is offered.
- R10: After reset the mode pins are ignored. The register's byte-order bit resets to the value `mode_big_end` had during reset.
- R11: A write drives its data with `bus_ad_oe` high and `bus_wr` high until `bus_ack`. A read never drives the lines during its data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_dref4 | input | 1 | Data-refill size of 4, sampled during reset |
| mode_big_end | input | 1 | Initial byte order, sampled during reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 7 | Control register value |
| rd_valid | input | 1 | Read request offered |
| rd_kind | input | 2 | 0 instruction refill, 1 data refill, 2 uncached |
| rd_addr | input | 32 | Read byte address |
| rd_size | input | 2 | Uncached access size |
| rd_accept | output | 1 | Read request taken this cycle |
| wr_valid | input | 1 | Write request offered |
| wr_addr | input | 32 | Write byte address |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data, lane-aligned |
| wr_accept | output | 1 | Write request taken this cycle |
| rdata_valid | output | 1 | Returned word valid |
| rdata_idx | output | 2 | Word index within the line |
| rdata | output | 32 | Returned word |
| done | output | 1 | Last word of the transaction |
| bus_ad_out | output | 32 | Value driven on shared lines |
| bus_ad_oe | output | 1 | Shared line drive enable |
| bus_ad_in | input | 32 | Value sampled from shared lines |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read data strobe |
| bus_wr | output | 1 | Write data strobe |
| bus_be | output | 4 | Byte lane enables |
| strb_a | output | 1 | Qualified memory strobe A |
| strb_b | output | 1 | Qualified memory strobe B |
| bus_ack | input | 1 | Per-word ready from memory |

## Verification
The sequencer is driven with a chain of read and write requests, each preceded by a register setting. Refills start at different words within the line, which separates correct wrap order from a plain count. Alternating read and write directions, with turnaround and hold switched on and off, separate the idle-gap, hold and latch cycles by their latency to the first strobe. Byte and half accesses at every offset in both byte orders separate lane mirroring from lane shifting. Directed runs hold a read and a write together, stall an acknowledge, rewrite the register mid-burst, and change the mode pins after reset.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        RK_IFETCH   = 2'd0,
        RK_DMISS    = 2'd1,
        RK_UNCACHED = 2'd2,
        RK_SPARE    = 2'd3
    } rkind_e;

    typedef enum logic [1:0] {
        AS_BYTE = 2'd0,
        AS_HALF = 2'd1,
        AS_WORD = 2'd2,
        AS_RSVD = 2'd3
    } asize_e;

    typedef enum logic [1:0] {
        SQ_NEVER = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_BOTH  = 2'd3
    } squal_e;

    // field order fixes the register bit positions: [6:5] B, [4:3] A, [2] endian, [1] hold, [0] turn
    typedef struct packed {
        squal_e qual_b;
        squal_e qual_a;
        logic   big_end;
        logic   hold_ext;
        logic   turn_ext;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_ADDR,
        ST_HOLD,
        ST_DATA
    } bstate_e;

    typedef struct packed {
        logic   is_wr;
        asize_e size;
    } txn_t;

    function automatic logic wants_burst(rkind_e kind, logic dref4);
        return (kind == RK_IFETCH) || ((kind == RK_DMISS) && dref4);
    endfunction

    function automatic logic qual_hit(squal_e q, logic is_wr);
        case (q)
            SQ_READ:  return !is_wr;
            SQ_WRITE: return is_wr;
            SQ_BOTH:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic int size_bytes(asize_e s, int nlane);
        case (s)
            AS_BYTE: return 1;
            AS_HALF: return (nlane < 2) ? nlane : 2;
            default: return (nlane < 4) ? nlane : 4;
        endcase
    endfunction

endpackage

// File: rtl/mbus_cfg.sv
module mbus_cfg
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_dref4,
    input  logic             mode_big_end,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    output ctl_t             ctl,
    output logic             dref4
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dref4        <= mode_dref4;
            ctl.qual_b   <= SQ_NEVER;
            ctl.qual_a   <= SQ_NEVER;
            ctl.big_end  <= mode_big_end;
            ctl.hold_ext <= 1'b0;
            ctl.turn_ext <= 1'b0;
        end else if (cfg_we) begin
            ctl <= ctl_t'(cfg_wdata);
        end
    end

endmodule

// File: rtl/mbus_lanes.sv
module mbus_lanes
    import mbus_pkg::*;
#(
    parameter int NLANE = 4,
    localparam int OFFW = $clog2(NLANE)
) (
    input  logic [OFFW-1:0]  offset,
    input  asize_e           size,
    input  logic             big_end,
    output logic [NLANE-1:0] be
);

    logic [NLANE-1:0] hit;
    int               nbytes;
    int               base;

    always_comb begin
        nbytes = size_bytes(size, NLANE);
        base   = int'(offset) & ~(nbytes - 1);
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign hit[i] = (i >= base) && (i < base + nbytes);
        assign be[i]  = big_end ? hit[NLANE-1-i] : hit[i];
    end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int DW    = 32,
    parameter int BURST = 4,
    localparam int OFFW = $clog2(DW / 8),
    localparam int IDXW = $clog2(BURST),
    localparam int LW   = $clog2(BURST) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_valid,
    input  rkind_e          rd_kind,
    input  logic [DW-1:0]   rd_addr,
    input  asize_e          rd_size,
    input  logic            wr_valid,
    input  logic [DW-1:0]   wr_addr,
    input  asize_e          wr_size,
    input  logic [DW-1:0]   wr_data,
    input  ctl_t            ctl_live,
    input  logic            dref4,
    input  logic            bus_ack,
    input  logic [DW-1:0]   bus_ad_in,
    output logic            rd_accept,
    output logic            wr_accept,
    output logic            rdata_valid,
    output logic [IDXW-1:0] rdata_idx,
    output logic [DW-1:0]   rdata,
    output logic            done,
    output logic [DW-1:0]   bus_ad_out,
    output logic            bus_ad_oe,
    output logic            bus_ale,
    output logic            bus_rd,
    output logic            bus_wr,
    output logic            strb_a,
    output logic            strb_b,
    output logic [OFFW-1:0] cur_offset,
    output txn_t            cur,
    output ctl_t            snap
);

    bstate_e         state;
    logic [DW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic [LW-1:0]   left_q;
    logic [IDXW-1:0] widx_q;
    logic            last_wr_q;
    logic            in_data;
    logic            last_word;
    logic            rd_burst;

    assign rd_accept = (state == ST_IDLE) && rd_valid;
    assign wr_accept = (state == ST_IDLE) && !rd_valid && wr_valid;
    assign rd_burst  = wants_burst(rd_kind, dref4);
    assign in_data   = (state == ST_DATA);
    assign last_word = (left_q == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            left_q    <= '0;
            widx_q    <= '0;
            last_wr_q <= 1'b0;
            cur       <= '{is_wr: 1'b0, size: AS_WORD};
            snap      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rd_accept) begin
                        addr_q    <= rd_addr;
                        cur.is_wr <= 1'b0;
                        cur.size  <= (rd_kind == RK_IFETCH || rd_kind == RK_DMISS) ? AS_WORD : rd_size;
                        left_q    <= rd_burst ? LW'(BURST) : LW'(1);
                        widx_q    <= rd_addr[OFFW +: IDXW];
                        snap      <= ctl_live;
                        last_wr_q <= 1'b0;
                        state     <= (ctl_live.turn_ext && last_wr_q) ? ST_TURN : ST_ADDR;
                    end else if (wr_accept) begin
                        addr_q    <= wr_addr;
                        wdata_q   <= wr_data;
                        cur.is_wr <= 1'b1;
                        cur.size  <= wr_size;
                        left_q    <= LW'(1);
                        widx_q    <= wr_addr[OFFW +: IDXW];
                        snap      <= ctl_live;
                        last_wr_q <= 1'b1;
                        state     <= (ctl_live.turn_ext && !last_wr_q) ? ST_TURN : ST_ADDR;
                    end
                end
                ST_TURN: state <= ST_ADDR;
                ST_ADDR: state <= snap.hold_ext ? ST_HOLD : ST_DATA;
                ST_HOLD: state <= ST_DATA;
                ST_DATA: begin
                    if (bus_ack) begin
                        widx_q <= widx_q + 1'b1;
                        left_q <= left_q - 1'b1;
                        if (last_word) begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_ale     = (state == ST_ADDR);
    assign bus_ad_oe   = (state == ST_ADDR) || (state == ST_HOLD) || (in_data && cur.is_wr);
    assign bus_ad_out  = ((state == ST_ADDR) || (state == ST_HOLD)) ? addr_q :
                         (in_data && cur.is_wr) ? wdata_q : '0;
    assign bus_rd      = in_data && !cur.is_wr;
    assign bus_wr      = in_data && cur.is_wr;
    assign strb_a      = in_data && qual_hit(snap.qual_a, cur.is_wr);
    assign strb_b      = in_data && qual_hit(snap.qual_b, cur.is_wr);
    assign rdata_valid = bus_rd && bus_ack;
    assign rdata_idx   = widx_q;
    assign rdata       = bus_ad_in;
    assign done        = in_data && bus_ack && last_word;
    assign cur_offset  = addr_q[OFFW-1:0];

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int DW    = 32,
    parameter int BURST = 4,
    localparam int NLANE = DW / 8,
    localparam int OFFW  = $clog2(NLANE),
    localparam int IDXW  = $clog2(BURST)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_dref4,
    input  logic             mode_big_end,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             rd_valid,
    input  logic [1:0]       rd_kind,
    input  logic [DW-1:0]    rd_addr,
    input  logic [1:0]       rd_size,
    output logic             rd_accept,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_addr,
    input  logic [1:0]       wr_size,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_accept,
    output logic             rdata_valid,
    output logic [IDXW-1:0]  rdata_idx,
    output logic [DW-1:0]    rdata,
    output logic             done,
    output logic [DW-1:0]    bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [DW-1:0]    bus_ad_in,
    output logic             bus_ale,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [NLANE-1:0] bus_be,
    output logic             strb_a,
    output logic             strb_b,
    input  logic             bus_ack
);

    ctl_t             ctl_live;
    ctl_t             snap;
    txn_t             cur;
    logic             dref4;
    logic [OFFW-1:0]  cur_offset;
    logic [NLANE-1:0] lane_be;

    mbus_cfg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .mode_dref4   (mode_dref4),
        .mode_big_end (mode_big_end),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .ctl          (ctl_live),
        .dref4        (dref4)
    );

    mbus_seq #(.DW(DW), .BURST(BURST)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .rd_valid    (rd_valid),
        .rd_kind     (rkind_e'(rd_kind)),
        .rd_addr     (rd_addr),
        .rd_size     (asize_e'(rd_size)),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_size     (asize_e'(wr_size)),
        .wr_data     (wr_data),
        .ctl_live    (ctl_live),
        .dref4       (dref4),
        .bus_ack     (bus_ack),
        .bus_ad_in   (bus_ad_in),
        .rd_accept   (rd_accept),
        .wr_accept   (wr_accept),
        .rdata_valid (rdata_valid),
        .rdata_idx   (rdata_idx),
        .rdata       (rdata),
        .done        (done),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .bus_ale     (bus_ale),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .strb_a      (strb_a),
        .strb_b      (strb_b),
        .cur_offset  (cur_offset),
        .cur         (cur),
        .snap        (snap)
    );

    mbus_lanes #(.NLANE(NLANE)) u_lanes (
        .offset  (cur_offset),
        .size    (cur.size),
        .big_end (snap.big_end),
        .be      (lane_be)
    );

    assign bus_be = (bus_rd || bus_wr) ? lane_be : '0;

endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_valid,
    input logic       rd_accept,
    input logic       wr_accept,
    input logic       rdata_valid,
    input logic       done,
    input logic       bus_ad_oe,
    input logic       bus_ale,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [3:0] bus_be,
    input logic       strb_a,
    input logic       strb_b,
    input logic       bus_ack
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale); // R4

    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (bus_ad_oe && !bus_rd && !bus_wr)); // R4

    AST_DIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R11

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_ad_oe); // R11

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> bus_ad_oe); // R11

    AST_STRB_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (strb_a || strb_b) |-> (bus_rd || bus_wr)); // R6

    AST_RDATA_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> (bus_rd && bus_ack)); // R3

    AST_ACCEPT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_accept && wr_accept)); // R9

    AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (rst)
        wr_accept |-> !rd_valid); // R9

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> !(rd_accept || wr_accept)); // R9

    AST_BE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !done) |=> (!bus_rd || $stable(bus_be))); // R7

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ack) |=> bus_rd); // R3

endmodule

bind mbus_ctrl mbus_ctrl_chk chk_i (.*);

// File: tb/mbus_ctrl_tb.sv
module mbus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_dref4 = 1'b1;
    logic        mode_big_end = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic        rd_valid = 1'b0;
    logic [1:0]  rd_kind = '0;
    logic [31:0] rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic        rd_accept;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_accept;
    logic        rdata_valid;
    logic [1:0]  rdata_idx;
    logic [31:0] rdata;
    logic        done;
    logic [31:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [31:0] bus_ad_in = '0;
    logic        bus_ale;
    logic        bus_rd;
    logic        bus_wr;
    logic [3:0]  bus_be;
    logic        strb_a;
    logic        strb_b;
    logic        bus_ack = 1'b0;

    always #4 clk = ~clk;

    mbus_ctrl dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // measurements of the last transaction
    logic        m_acc;
    int          m_words, m_lat, m_ale, m_hold, m_rbad;
    logic [1:0]  m_first, m_last;
    logic [3:0]  m_be;
    logic        m_sa, m_sb, m_sa_last;
    logic [31:0] m_adr, m_wd;

    task automatic set_cfg(input logic [6:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_txn(input logic w, input logic [1:0] kind, input logic [31:0] addr,
                           input logic [1:0] size, input logic [31:0] wd,
                           input logic mid_en, input logic [6:0] mid_cfg);
        bit first_rd;
        @(negedge clk);
        if (w) begin
            wr_valid = 1'b1; wr_addr = addr; wr_size = size; wr_data = wd;
        end else begin
            rd_valid = 1'b1; rd_kind = kind; rd_addr = addr; rd_size = size;
        end
        #1;
        m_acc = w ? wr_accept : rd_accept;
        @(negedge clk);
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        m_words = 0; m_lat = -1; m_ale = 0; m_hold = 0; m_rbad = 0;
        m_first = '0; m_last = '0; m_be = '0; m_sa = 1'b0; m_sb = 1'b0; m_sa_last = 1'b0;
        m_adr = '0; m_wd = '0;
        first_rd = 1'b1;
        for (int c = 0; c < 40; c++) begin
            if (bus_ale) begin
                m_ale++;
                m_adr = bus_ad_out;
            end else if (bus_ad_oe && !bus_rd && !bus_wr) begin
                m_hold++;
            end
            if (bus_rd || bus_wr) begin
                if (m_words == 0) begin
                    m_lat = c; m_be = bus_be; m_sa = strb_a; m_sb = strb_b; m_wd = bus_ad_out;
                    if (mid_en) begin
                        cfg_we = 1'b1;
                        cfg_wdata = mid_cfg;
                    end
                end
                m_sa_last = strb_a;
                bus_ack = 1'b1;
                bus_ad_in = 32'hA500_0000 | c;
                #1;
                if (rdata_valid) begin
                    if (first_rd) m_first = rdata_idx;
                    first_rd = 1'b0;
                    m_last = rdata_idx;
                    if (rdata != bus_ad_in) m_rbad++;
                end
                m_words++;
                if (done) begin
                    @(negedge clk);
                    bus_ack = 1'b0;
                    cfg_we = 1'b0;
                    break;
                end
            end
            @(negedge clk);
            bus_ack = 1'b0;
            cfg_we = 1'b0;
        end
    endtask

    typedef struct packed {
        logic [6:0]  cfg;
        logic        w;
        logic [1:0]  kind;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [2:0]  words;
        logic [1:0]  first;
        logic [1:0]  last;
        logic [3:0]  be;
        logic [2:0]  lat;
        logic        hold;
        logic        sa;
        logic        sb;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{7'h00, 1'b0, 2'd0, 32'h0000_0100, 2'd2, 3'd4, 2'd0, 2'd3, 4'hF, 3'd1, 1'b0, 1'b0, 1'b0},
        '{7'h08, 1'b0, 2'd0, 32'h0000_0108, 2'd2, 3'd4, 2'd2, 2'd1, 4'hF, 3'd1, 1'b0, 1'b1, 1'b0},
        '{7'h00, 1'b0, 2'd2, 32'h0000_0203, 2'd0, 3'd1, 2'd0, 2'd0, 4'h8, 3'd1, 1'b0, 1'b0, 1'b0},
        '{7'h04, 1'b0, 2'd2, 32'h0000_0203, 2'd0, 3'd1, 2'd0, 2'd0, 4'h1, 3'd1, 1'b0, 1'b0, 1'b0},
        '{7'h04, 1'b0, 2'd2, 32'h0000_0202, 2'd1, 3'd1, 2'd0, 2'd0, 4'h3, 3'd1, 1'b0, 1'b0, 1'b0},
        '{7'h00, 1'b0, 2'd2, 32'h0000_0206, 2'd1, 3'd1, 2'd1, 2'd1, 4'hC, 3'd1, 1'b0, 1'b0, 1'b0},
        '{7'h02, 1'b0, 2'd1, 32'h0000_030C, 2'd2, 3'd4, 2'd3, 2'd2, 4'hF, 3'd2, 1'b1, 1'b0, 1'b0},
        '{7'h01, 1'b1, 2'd0, 32'h0000_0400, 2'd2, 3'd1, 2'd0, 2'd0, 4'hF, 3'd2, 1'b0, 1'b0, 1'b0},
        '{7'h71, 1'b1, 2'd0, 32'h0000_0405, 2'd0, 3'd1, 2'd0, 2'd0, 4'h2, 3'd1, 1'b0, 1'b1, 1'b1},
        '{7'h71, 1'b0, 2'd2, 32'h0000_0410, 2'd2, 3'd1, 2'd0, 2'd0, 4'hF, 3'd2, 1'b0, 1'b0, 1'b1},
        '{7'h07, 1'b1, 2'd0, 32'h0000_0500, 2'd1, 3'd1, 2'd0, 2'd0, 4'hC, 3'd3, 1'b1, 1'b0, 1'b0},
        '{7'h00, 1'b0, 2'd1, 32'h0000_00C4, 2'd2, 3'd4, 2'd1, 2'd0, 4'hF, 3'd1, 1'b0, 1'b0, 1'b0}
    };

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset with 4-word data refill and little-endian order
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mode_dref4 = 1'b0;
        mode_big_end = 1'b1;
        @(negedge clk);
        chk(!bus_ale && !bus_ad_oe && !bus_rd && !bus_wr, "R4", "idle after reset",
            {bus_ale, bus_ad_oe, bus_rd, bus_wr}, 0);
        chk(!strb_a && !strb_b && !done && !rdata_valid, "R6", "strobes idle after reset",
            {strb_a, strb_b, done, rdata_valid}, 0);

        // R10: mode pins changed after reset must not matter
        run_txn(1'b0, 2'd2, 32'h0000_0000, 2'd0, 0, 1'b0, 0);
        chk(m_be == 4'h1, "R10", "byte order kept from reset", m_be, 4'h1);
        run_txn(1'b0, 2'd1, 32'h0000_0040, 2'd2, 0, 1'b0, 0);
        chk(m_words == 4, "R10", "refill size kept from reset", m_words, 4);

        // vector table
        for (int i = 0; i < NV; i++) begin
            set_cfg(TBL[i].cfg);
            run_txn(TBL[i].w, TBL[i].kind, TBL[i].addr, TBL[i].size, 32'hC0DE_0000 | i, 1'b0, 0);
            chk(m_acc == 1'b1, "R9", $sformatf("v%0d accept", i), m_acc, 1);
            chk(m_words == int'(TBL[i].words), "R1", $sformatf("v%0d word count", i), m_words, TBL[i].words);
            chk(m_ale == 1 && m_adr == TBL[i].addr, "R4", $sformatf("v%0d latch address", i), m_adr, TBL[i].addr);
            chk(m_hold == int'(TBL[i].hold), "R4", $sformatf("v%0d hold cycles", i), m_hold, TBL[i].hold);
            chk(m_lat == int'(TBL[i].lat), "R5", $sformatf("v%0d latency", i), m_lat, TBL[i].lat);
            chk(m_be == TBL[i].be, "R7", $sformatf("v%0d byte enables", i), m_be, TBL[i].be);
            chk(m_sa == TBL[i].sa && m_sb == TBL[i].sb, "R6", $sformatf("v%0d strobes", i),
                {m_sa, m_sb}, {TBL[i].sa, TBL[i].sb});
            if (TBL[i].w) begin
                chk(m_wd == (32'hC0DE_0000 | i), "R11", $sformatf("v%0d write data", i), m_wd, 32'hC0DE_0000 | i);
            end else begin
                chk(m_first == TBL[i].first && m_last == TBL[i].last && m_rbad == 0, "R3",
                    $sformatf("v%0d word order", i), {m_first, m_last}, {TBL[i].first, TBL[i].last});
            end
        end

        // R9 and R3: read beats write, write waits, stalled acknowledge
        set_cfg(7'h00);
        @(negedge clk);
        rd_valid = 1'b1; rd_kind = 2'd2; rd_addr = 32'h0000_0600; rd_size = 2'd2;
        wr_valid = 1'b1; wr_addr = 32'h0000_0604; wr_size = 2'd2; wr_data = 32'h1234_5678;
        #1;
        chk(rd_accept && !wr_accept, "R9", "read wins", {rd_accept, wr_accept}, 2'b10);
        @(negedge clk);
        rd_valid = 1'b0;
        chk(!wr_accept, "R9", "write held during latch", wr_accept, 0);
        @(negedge clk);
        #1;
        chk(bus_rd && !rdata_valid && !wr_accept, "R3", "stall without ack",
            {bus_rd, rdata_valid, wr_accept}, 3'b100);
        @(negedge clk);
        bus_ack = 1'b1;
        bus_ad_in = 32'h0BAD_F00D;
        #1;
        chk(rdata_valid && done && rdata == 32'h0BAD_F00D, "R3", "word after stall", rdata, 32'h0BAD_F00D);
        @(negedge clk);
        bus_ack = 1'b0;
        #1;
        chk(wr_accept, "R9", "write taken once idle", wr_accept, 1);
        @(negedge clk);
        wr_valid = 1'b0;
        for (int c = 0; c < 10; c++) begin
            if (bus_wr) begin
                chk(bus_ad_oe && bus_ad_out == 32'h1234_5678, "R11", "queued write data", bus_ad_out, 32'h1234_5678);
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
                break;
            end
            @(negedge clk);
        end

        // R8: register rewrite mid-burst
        set_cfg(7'h08);
        run_txn(1'b0, 2'd0, 32'h0000_0700, 2'd2, 0, 1'b1, 7'h00);
        chk(m_sa_last == 1'b1, "R8", "strobe kept through burst", m_sa_last, 1);
        run_txn(1'b0, 2'd2, 32'h0000_0704, 2'd2, 0, 1'b0, 0);
        chk(m_sa == 1'b0, "R8", "new setting on next transaction", m_sa, 0);

        // R2: reset again with single-word data refill
        @(negedge clk);
        rst = 1'b1;
        mode_dref4 = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mode_dref4 = 1'b1;
        run_txn(1'b0, 2'd1, 32'h0000_0808, 2'd2, 0, 1'b0, 0);
        chk(m_words == 1, "R2", "single-word data refill", m_words, 1);
        run_txn(1'b0, 2'd0, 32'h0000_080C, 2'd2, 0, 1'b0, 0);
        chk(m_words == 4 && m_first == 2'd3 && m_last == 2'd2, "R1", "instruction refill stays 4", m_words, 4);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule